// File: doc/BRIEF.md
# I2C Status and Event Controller

This block collects the status of a byte-oriented I2C controller that works as either bus master or bus slave. The bus engine reports what happened as one-cycle set pulses (byte finished, own address matched, start sent, 10-bit header sent, address phase done, missing acknowledge, stop seen, arbitration lost, bus error) and as levels (transmit direction, bus busy, role). The block keeps these as sticky flags in two read-only status words and folds them into a single event summary bit.

The event summary bit drives two things. It raises the interrupt output when software has enabled interrupts. It also holds SCL low through a clock-stretch request while a non-error event waits for service. Software clears events in two ways. It reads the main status word and then accesses the data register, or it reads the error status word. A stop request bit, written by software, tells the bus engine either to generate a Stop or to release the lines. Which of the two it does depends on the role.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: Synchronous reset clears every status bit, the error word, the interrupt enable, the stop request and all outputs to 0.
- R2: The main status word `stat_o` has bit 7 event summary, bit 6 header sent, bit 5 transmit direction, bit 4 bus busy, bit 3 byte finished, bit 2 address matched, bit 1 master role, bit 0 start sent. It is updated one clock after its inputs.
- R3: The event summary rises in the cycle after any source is pulsed. An address match counts only while `ack_en_i` is 1. Start sent, address phase done and arbitration lost count only in master role. Stop seen counts only in slave role.
- R4: The non-error flags (header, byte finished, address matched, start, address phase done) clear on a `data_acc_i` pulse that follows an earlier `stat_rd_i` pulse. A `data_acc_i` pulse without a prior read clears nothing. A set pulse in the clearing cycle wins. The event summary drops in the same cycle that its last source clears.
- R5: The error word `err_o` holds bus error at bit 0, arbitration lost at bit 1, missing acknowledge at bit 2 and stop seen at bit 3. One `err_rd_i` pulse clears all of them. The event summary stays set if any non-error flag remains.
- R6: While `en_i` is 0, all flags, the error word, the event summary and the interrupt enable are held at 0, and set pulses and enable writes are ignored.
- R7: Software writes the interrupt enable through `ie_wr_i`/`ie_wdata_i`. `irq_o` is a registered copy of event summary AND interrupt enable AND `en_i`.
- R8: `scl_hold_o` is 1 exactly while header sent, start sent, byte finished, address matched or address phase done is set. Error events do not stretch the clock.
- R9: In master role, `stop_gen_o` is 1 while the stop request is set and either byte finished or start sent is set. A `stop_sent_i` pulse clears the stop request.
- R10: In slave role, `release_o` is 1 while the stop request and byte finished are both set. `stop_sent_i` does not clear the request; only a software write does.
- R11: Dropping `en_i` leaves the stop request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Peripheral enable |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| dir_tx_i | input | 1 | Transmit direction level |
| busy_i | input | 1 | Bus busy level |
| ack_en_i | input | 1 | Acknowledge enabled level |
| hdr10_set_i | input | 1 | 10-bit header sent pulse |
| xfer_done_set_i | input | 1 | Byte finished pulse |
| addr_hit_set_i | input | 1 | Own address matched pulse |
| start_set_i | input | 1 | Start sent pulse |
| addr_sent_set_i | input | 1 | Master address phase done pulse |
| nack_set_i | input | 1 | Missing acknowledge pulse |
| stop_det_set_i | input | 1 | Stop seen pulse |
| arb_lost_set_i | input | 1 | Arbitration lost pulse |
| bus_err_set_i | input | 1 | Bus error pulse |
| stat_rd_i | input | 1 | Main status word read strobe |
| err_rd_i | input | 1 | Error word read strobe |
| data_acc_i | input | 1 | Data register access strobe |
| ie_wr_i | input | 1 | Interrupt enable write strobe |
| ie_wdata_i | input | 1 | Interrupt enable write value |
| stop_wr_i | input | 1 | Stop request write strobe |
| stop_wdata_i | input | 1 | Stop request write value |
| stop_sent_i | input | 1 | Stop condition completed pulse |
| stat_o | output | SR_W | Main status word |
| err_o | output | SR_W | Error status word |
| evt_o | output | 1 | Event summary |
| irq_en_o | output | 1 | Interrupt enable state |
| stop_req_o | output | 1 | Stop request state |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Clock-stretch request |
| stop_gen_o | output | 1 | Request to issue a Stop (master) |
| release_o | output | 1 | Request to release SCL and SDA (slave) |

## Verification
The bench builds the block with its default widths: an 8-bit status word, five non-error flags and four error flags. With these values, every bit of both status words has a fixed position that a check can name. This lets the bench reach the role gating of each source and the read-then-access clear order. It also reaches the case where a set and a clear land in the same cycle, and both stop-request behaviours across a drop of the enable.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int SR_W   = 8;
  localparam int FLAG_W = 5;
  localparam int ERR_W  = 4;

  // non-error flag indices
  localparam int F_HDR   = 0;
  localparam int F_XFER  = 1;
  localparam int F_HIT   = 2;
  localparam int F_START = 3;
  localparam int F_ADDR  = 4;

  // error flag indices (also positions in the error word)
  localparam int E_BERR = 0;
  localparam int E_ARB  = 1;
  localparam int E_NACK = 2;
  localparam int E_SDET = 3;

  // main status word positions
  localparam int S_START = 0;
  localparam int S_MST   = 1;
  localparam int S_HIT   = 2;
  localparam int S_XFER  = 3;
  localparam int S_BUSY  = 4;
  localparam int S_TX    = 5;
  localparam int S_HDR   = 6;
  localparam int S_EVT   = 7;
endpackage

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] set_i,
  input  logic         stat_rd_i,
  input  logic         data_acc_i,
  output logic [W-1:0] flags_n_o,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic         arm_q, arm_n, clr;

  always_comb begin
    clr = arm_q & data_acc_i;
    if (!en_i)           arm_n = 1'b0;
    else if (stat_rd_i)  arm_n = 1'b1;
    else if (data_acc_i) arm_n = 1'b0;
    else                 arm_n = arm_q;
    flags_n_o = en_i ? ((flags_q & ~{W{clr}}) | set_i) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      arm_q   <= 1'b0;
    end else begin
      flags_q <= flags_n_o;
      arm_q   <= arm_n;
    end
  end

  assign flags_o = flags_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    en_i && !data_acc_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
  AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> flags_q == '0); // R6
endmodule

// File: rtl/i2c_evt_errs.sv
module i2c_evt_errs #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] errs_n_o,
  output logic [W-1:0] errs_o
);
  logic [W-1:0] errs_q;

  always_comb
    errs_n_o = en_i ? ((errs_q & ~{W{rd_i}}) | set_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) errs_q <= '0;
    else     errs_q <= errs_n_o;
  end

  assign errs_o = errs_q;

  AST_ERR_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    rd_i && set_i == '0 |=> errs_q == '0); // R5
endmodule

// File: rtl/i2c_evt_stop.sv
module i2c_evt_stop (
  input  logic clk,
  input  logic rst,
  input  logic master_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic sent_i,
  output logic stop_n_o,
  output logic stop_o
);
  logic stop_q;

  always_comb begin
    if (wr_i)                  stop_n_o = wdata_i;
    else if (master_i && sent_i) stop_n_o = 1'b0;
    else                       stop_n_o = stop_q;
  end

  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b0;
    else     stop_q <= stop_n_o;
  end

  assign stop_o = stop_q;

  AST_SLAVE_STOP_KEPT: assert property (@(posedge clk) disable iff (rst)
    stop_q && !master_i && !wr_i |=> stop_q); // R10
  AST_MASTER_STOP_DONE: assert property (@(posedge clk) disable iff (rst)
    master_i && sent_i && !wr_i |=> !stop_q); // R9
endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
#(
  parameter int SR_W_P   = SR_W,
  parameter int FLAG_W_P = FLAG_W,
  parameter int ERR_W_P  = ERR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              dir_tx_i,
  input  logic              busy_i,
  input  logic              ack_en_i,
  input  logic              hdr10_set_i,
  input  logic              xfer_done_set_i,
  input  logic              addr_hit_set_i,
  input  logic              start_set_i,
  input  logic              addr_sent_set_i,
  input  logic              nack_set_i,
  input  logic              stop_det_set_i,
  input  logic              arb_lost_set_i,
  input  logic              bus_err_set_i,
  input  logic              stat_rd_i,
  input  logic              err_rd_i,
  input  logic              data_acc_i,
  input  logic              ie_wr_i,
  input  logic              ie_wdata_i,
  input  logic              stop_wr_i,
  input  logic              stop_wdata_i,
  input  logic              stop_sent_i,
  output logic [SR_W_P-1:0] stat_o,
  output logic [SR_W_P-1:0] err_o,
  output logic              evt_o,
  output logic              irq_en_o,
  output logic              stop_req_o,
  output logic              irq_o,
  output logic              scl_hold_o,
  output logic              stop_gen_o,
  output logic              release_o
);
  localparam int PAD_W = SR_W_P - ERR_W_P;

  logic [FLAG_W_P-1:0] flag_set, flags_n, flags_q;
  logic [ERR_W_P-1:0]  err_set, errs_n, errs_q;
  logic                stop_n, stop_q;
  logic                ie_q, ie_n, evt_n;
  logic [SR_W_P-1:0]   stat_q, stat_n;
  logic                evt_q, irq_q, scl_q, gen_q, rel_q;

  always_comb begin
    flag_set          = '0;
    flag_set[F_HDR]   = hdr10_set_i;
    flag_set[F_XFER]  = xfer_done_set_i;
    flag_set[F_HIT]   = addr_hit_set_i & ack_en_i;
    flag_set[F_START] = start_set_i & master_i;
    flag_set[F_ADDR]  = addr_sent_set_i & master_i;
    err_set           = '0;
    err_set[E_BERR]   = bus_err_set_i;
    err_set[E_ARB]    = arb_lost_set_i & master_i;
    err_set[E_NACK]   = nack_set_i;
    err_set[E_SDET]   = stop_det_set_i & ~master_i;
  end

  i2c_evt_flags #(.W(FLAG_W_P)) u_flags (
    .clk(clk), .rst(rst), .en_i(en_i), .set_i(flag_set),
    .stat_rd_i(stat_rd_i), .data_acc_i(data_acc_i),
    .flags_n_o(flags_n), .flags_o(flags_q)
  );

  i2c_evt_errs #(.W(ERR_W_P)) u_errs (
    .clk(clk), .rst(rst), .en_i(en_i), .set_i(err_set), .rd_i(err_rd_i),
    .errs_n_o(errs_n), .errs_o(errs_q)
  );

  i2c_evt_stop u_stop (
    .clk(clk), .rst(rst), .master_i(master_i), .wr_i(stop_wr_i),
    .wdata_i(stop_wdata_i), .sent_i(stop_sent_i),
    .stop_n_o(stop_n), .stop_o(stop_q)
  );

  always_comb begin
    if (!en_i)        ie_n = 1'b0;
    else if (ie_wr_i) ie_n = ie_wdata_i;
    else              ie_n = ie_q;
    evt_n           = (|flags_n) | (|errs_n);
    stat_n          = '0;
    stat_n[S_EVT]   = evt_n;
    stat_n[S_HDR]   = flags_n[F_HDR];
    stat_n[S_TX]    = dir_tx_i;
    stat_n[S_BUSY]  = busy_i;
    stat_n[S_XFER]  = flags_n[F_XFER];
    stat_n[S_HIT]   = flags_n[F_HIT];
    stat_n[S_MST]   = master_i;
    stat_n[S_START] = flags_n[F_START];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      evt_q  <= 1'b0;
      irq_q  <= 1'b0;
      scl_q  <= 1'b0;
      gen_q  <= 1'b0;
      rel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      ie_q   <= ie_n;
      evt_q  <= evt_n;
      irq_q  <= evt_n & ie_n & en_i;
      scl_q  <= |flags_n;
      gen_q  <= stop_n & master_i & en_i & (flags_n[F_XFER] | flags_n[F_START]);
      rel_q  <= stop_n & ~master_i & en_i & flags_n[F_XFER];
      stat_q <= stat_n;
    end
  end

  assign stat_o     = stat_q;
  assign err_o      = {{PAD_W{1'b0}}, errs_q};
  assign evt_o      = evt_q;
  assign irq_en_o   = ie_q;
  assign stop_req_o = stop_q;
  assign irq_o      = irq_q;
  assign scl_hold_o = scl_q;
  assign stop_gen_o = gen_q;
  assign release_o  = rel_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_en_o && evt_o); // R7
  AST_HOLD_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    scl_hold_o |-> evt_o); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !evt_o && !irq_en_o && !irq_o); // R6
  AST_GEN_REL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stop_gen_o && release_o)); // R9
  AST_STOP_KEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i && !stop_wr_i && !stop_sent_i |=> $stable(stop_req_o)); // R11
endmodule

// File: tb/i2c_evt_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_evt_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [21:0] stim = '0;
  logic [7:0]  stat_o, err_o;
  logic evt_o, irq_en_o, stop_req_o, irq_o, scl_hold_o, stop_gen_o, release_o;

  i2c_evt_ctrl u_i2c_evt_ctrl (
    .clk(clk), .rst(rst),
    .en_i(stim[0]), .master_i(stim[1]), .ack_en_i(stim[2]),
    .hdr10_set_i(stim[3]), .xfer_done_set_i(stim[4]), .addr_hit_set_i(stim[5]),
    .start_set_i(stim[6]), .addr_sent_set_i(stim[7]), .nack_set_i(stim[8]),
    .stop_det_set_i(stim[9]), .arb_lost_set_i(stim[10]), .bus_err_set_i(stim[11]),
    .stat_rd_i(stim[12]), .err_rd_i(stim[13]), .data_acc_i(stim[14]),
    .ie_wr_i(stim[15]), .ie_wdata_i(stim[16]), .stop_wr_i(stim[17]),
    .stop_wdata_i(stim[18]), .stop_sent_i(stim[19]),
    .dir_tx_i(stim[20]), .busy_i(stim[21]),
    .stat_o(stat_o), .err_o(err_o), .evt_o(evt_o), .irq_en_o(irq_en_o),
    .stop_req_o(stop_req_o), .irq_o(irq_o), .scl_hold_o(scl_hold_o),
    .stop_gen_o(stop_gen_o), .release_o(release_o)
  );

  localparam logic [21:0] I_EN = 22'd1 << 0,  I_MST = 22'd1 << 1,  I_ACK = 22'd1 << 2;
  localparam logic [21:0] I_HDR = 22'd1 << 3, I_XFER = 22'd1 << 4, I_HIT = 22'd1 << 5;
  localparam logic [21:0] I_START = 22'd1 << 6, I_ADDR = 22'd1 << 7, I_NACK = 22'd1 << 8;
  localparam logic [21:0] I_SDET = 22'd1 << 9, I_ARB = 22'd1 << 10, I_BERR = 22'd1 << 11;
  localparam logic [21:0] I_SRD = 22'd1 << 12, I_ERD = 22'd1 << 13, I_DACC = 22'd1 << 14;
  localparam logic [21:0] I_IEW = 22'd1 << 15, I_IED = 22'd1 << 16, I_SW = 22'd1 << 17;
  localparam logic [21:0] I_SD = 22'd1 << 18, I_SENT = 22'd1 << 19, I_TX = 22'd1 << 20;
  localparam logic [21:0] I_BUSY = 22'd1 << 21;
  localparam logic [21:0] M = I_EN | I_MST;

  localparam logic [18:0] X_EVT = 19'd1 << 0, X_IRQ = 19'd1 << 1, X_IE = 19'd1 << 2;
  localparam logic [18:0] X_SREQ = 19'd1 << 3, X_SCL = 19'd1 << 4, X_SGEN = 19'd1 << 5;
  localparam logic [18:0] X_REL = 19'd1 << 6;
  localparam logic [18:0] S0 = 19'd1 << 7, S1 = 19'd1 << 8, S2 = 19'd1 << 9, S3 = 19'd1 << 10;
  localparam logic [18:0] S4 = 19'd1 << 11, S5 = 19'd1 << 12, S6 = 19'd1 << 13, S7 = 19'd1 << 14;
  localparam logic [18:0] E0 = 19'd1 << 15, E1 = 19'd1 << 16, E2 = 19'd1 << 17, E3 = 19'd1 << 18;
  localparam logic [18:0] ACT = X_EVT | X_IRQ | X_IE | S7;

  localparam int NV = 35;
  localparam logic [21:0] STIM [NV] = '{
    M | I_IEW | I_IED,                 // 0  R7 enable interrupts
    M | I_START,                       // 1  R3 start in master
    M | I_DACC,                        // 2  R4 access without read
    M | I_SRD,                         // 3  R4 arm
    M | I_DACC,                        // 4  R4 clear
    M | I_SW | I_SD,                   // 5  R9 request stop, nothing pending
    M | I_XFER,                        // 6  R9 byte done -> stop generation
    M | I_SENT,                        // 7  R9 stop sent clears request
    M | I_SRD,                         // 8  R4
    M | I_DACC,                        // 9  R4
    M | I_ARB,                         // 10 R5 arbitration lost
    M | I_NACK | I_HDR,                // 11 R5 R8 nack plus header
    M | I_ERD,                         // 12 R5 error read, header keeps event
    M | I_SRD,                         // 13 R4
    M | I_DACC,                        // 14 R4
    M | I_ADDR,                        // 15 R8 address phase done stretches
    M | I_SDET,                        // 16 R3 stop seen ignored in master
    M | I_SRD,                         // 17 R4
    M | I_DACC,                        // 18 R4
    I_EN | I_HIT,                      // 19 R3 match without ack ignored
    I_EN | I_ACK | I_HIT | I_TX | I_BUSY, // 20 R2 slave match
    I_EN | I_START | I_ARB | I_ADDR,   // 21 R3 master-only sources ignored
    I_EN | I_SW | I_SD | I_SRD,        // 22 R10 slave stop, no byte yet
    I_EN | I_XFER | I_DACC,            // 23 R10 R4 set beats clear, release
    I_EN | I_SENT,                     // 24 R10 stop sent ignored in slave
    I_EN | I_SDET,                     // 25 R5 stop seen in slave
    I_EN | I_IEW,                      // 26 R7 disable interrupts
    22'd0,                             // 27 R11 R6 disable block
    I_XFER | I_BERR | I_IEW | I_IED,   // 28 R6 ignored while disabled
    M | I_IEW | I_IED | I_SW,          // 29 R10 software clears stop
    M | I_BERR,                        // 30 R5 bus error
    M | I_ERD,                         // 31 R5
    M | I_SW | I_SD,                   // 32 R9
    M | I_START,                       // 33 R9 start pending -> stop generation
    M | I_SENT                         // 34 R9
  };
  localparam logic [18:0] EXP [NV] = '{
    X_IE | S1,
    ACT | X_SCL | S1 | S0,
    ACT | X_SCL | S1 | S0,
    ACT | X_SCL | S1 | S0,
    X_IE | S1,
    X_IE | X_SREQ | S1,
    ACT | X_SREQ | X_SCL | X_SGEN | S3 | S1,
    ACT | X_SCL | S3 | S1,
    ACT | X_SCL | S3 | S1,
    X_IE | S1,
    ACT | S1 | E1,
    ACT | X_SCL | S6 | S1 | E1 | E2,
    ACT | X_SCL | S6 | S1,
    ACT | X_SCL | S6 | S1,
    X_IE | S1,
    ACT | X_SCL | S1,
    ACT | X_SCL | S1,
    ACT | X_SCL | S1,
    X_IE | S1,
    X_IE,
    ACT | X_SCL | S5 | S4 | S2,
    ACT | X_SCL | S2,
    ACT | X_SREQ | X_SCL | S2,
    ACT | X_SREQ | X_SCL | X_REL | S3,
    ACT | X_SREQ | X_SCL | X_REL | S3,
    ACT | X_SREQ | X_SCL | X_REL | S3 | E3,
    X_EVT | X_SREQ | X_SCL | X_REL | S7 | S3 | E3,
    X_SREQ,
    X_SREQ,
    X_IE | S1,
    ACT | S1 | E0,
    X_IE | S1,
    X_IE | X_SREQ | S1,
    ACT | X_SREQ | X_SCL | X_SGEN | S1 | S0,
    ACT | X_SCL | S1 | S0
  };
  localparam int REQ [NV] = '{7, 3, 4, 4, 4, 9, 9, 9, 4, 4, 5, 5, 5, 4, 4, 8, 3, 4, 4,
                              3, 2, 3, 10, 10, 10, 5, 7, 11, 6, 10, 5, 5, 9, 9, 9};

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [18:0] observe();
    return {err_o[3:0], stat_o, release_o, stop_gen_o, scl_hold_o,
            stop_req_o, irq_en_o, irq_o, evt_o};
  endfunction

  task automatic check(input logic [18:0] act, input logic [18:0] exp, input int req,
                       input int step);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d step %0d actual=%h expected=%h", req, step, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        done = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(observe(), 19'd0, 1, -1); // R1 reset state
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stim = STIM[i];
      @(posedge clk);
      #1;
      check(observe(), EXP[i], REQ[i], i);
    end
    // R1: reset with flags and stop request pending
    @(negedge clk);
    stim = M | I_SW | I_SD | I_XFER | I_NACK;
    @(posedge clk);
    #1;
    check(observe(), ACT | X_SREQ | X_SCL | X_SGEN | S3 | S1 | S0 | E2, 9, 100);
    @(negedge clk);
    rst = 1'b1;
    stim = M;
    @(posedge clk);
    #1;
    check(observe(), 19'd0, 1, 101); // R1
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(observe(), S1, 1, 102); // R1 nothing returns after reset
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule